// File: doc/BRIEF.md
# Lockable SPI Memory Status Register

This block keeps the eight-bit status register of a serial memory device. The register carries a lock bit, a four-bit array protection field, the write-enable latch and a busy flag. A command decoder elsewhere raises a one-cycle write request together with a data byte. The block then decides whether to take the byte, using the write-enable latch, the lock bit and the active-low write-protect pin.

The lock bit only takes effect while the protect pin is held low. While the pin is high the register can be written whenever the latch is set, whatever the lock bit holds. Every write attempt clears the write-enable latch, whether it is accepted or refused. Each attempt also produces exactly one result pulse, either accepted or refused, in the cycle after the request. The protection field is also brought out on its own output for the array protection logic.

Top module: `sr_lockdown_status`

## Requirements
- R1: After reset the status output reads 0x3C: lock bit 0, protection field all ones, latch 0, busy 0. Both result pulses are low.
- R2: Status bit 7 is the lock bit and bits 5 down to 2 form the protection field. The `prot_o` output always equals status bits 5 down to 2.
- R3: When the latch is set, the protect pin is low and the lock bit is 1, a write attempt is refused. Status bits 7 down to 2 keep their values.
- R4: When the latch is set, the protect pin is low and the lock bit is 0, a write attempt is accepted. Status bit 7 takes data bit 7 and bits 5 down to 2 take data bits 5 down to 2.
- R5: When the latch is set and the protect pin is high, a write attempt is accepted whatever the lock bit holds, and the bits are updated as in R4.
- R6: When the latch is clear, a write attempt is refused whatever the pin and the lock bit hold, and status bits 7 down to 2 keep their values.
- R7: A latch-set strobe sets status bit 1 on the next cycle. Every write attempt leaves bit 1 cleared. When a set strobe and a write attempt arrive in the same cycle, the attempt is judged on the latch value from before that cycle, and the latch ends up cleared.
- R8: Data bits 6, 1 and 0 have no effect. Status bit 6 always reads 0, and status bit 0 shows the `busy_i` level of the previous cycle.
- R9: Each write attempt raises exactly one of `wr_ok_o` and `wr_rej_o`, for one cycle, in the cycle after the request. Neither pulse rises without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | One-cycle write-status request strobe |
| wr_data_i | input | 8 | Byte offered for the status register |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wel_set_i | input | 1 | Strobe that sets the write-enable latch |
| busy_i | input | 1 | Busy level to show in bit 0 |
| status_o | output | 8 | Current status register value |
| prot_o | output | 4 | Array protection field |
| wr_ok_o | output | 1 | Pulse: the last write attempt was accepted |
| wr_rej_o | output | 1 | Pulse: the last write attempt was refused |

## Verification
A write attempt and a latch-set strobe can arrive in the same cycle, and the result depends on which one wins. The bench provokes this collision with the latch both clear and already set. It expects the verdict to follow the old latch value and the latch to end up clear. All other attempts are swept over every combination of pin level, lock bit and latch state with several data bytes, and each outcome is compared against an arithmetic model kept in the bench.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int SR_W      = 8;
    localparam int LOCK_BIT  = 7;
    localparam int SPARE_BIT = 6;
    localparam int PROT_W    = 4;
    localparam int PROT_LSB  = 2;
    localparam int PROT_MSB  = PROT_LSB + PROT_W - 1;
    localparam int WEL_BIT   = 1;
    localparam int BUSY_BIT  = 0;

    typedef struct packed {
        logic              lock;
        logic [PROT_W-1:0] prot;
        logic              busy;
        logic              ok;
        logic              rej;
    } sr_state_t;
endpackage

// File: rtl/sr_wr_gate.sv
module sr_wr_gate (
    input  logic req_i,
    input  logic wel_i,
    input  logic lock_i,
    input  logic wp_n_i,
    output logic accept_o,
    output logic refuse_o
);
    logic pin_allows;

    always_comb begin
        // Lock only matters while the pin is low; a high pin disables it.
        pin_allows = wp_n_i | ~lock_i;
        accept_o   = req_i & wel_i & pin_allows;
        refuse_o   = req_i & ~(wel_i & pin_allows);
    end
endmodule

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic wel_d, wel_q;

    always_comb begin
        wel_d = wel_q;
        if (set_i) wel_d = 1'b1;
        if (clr_i) wel_d = 1'b0;   // attempt outranks a same-cycle set
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_q <= 1'b0;
        else        wel_q <= wel_d;
    end

    assign q_o = wel_q;

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> q_o);
endmodule

// File: rtl/sr_lockdown_status.sv
module sr_lockdown_status
    import sr_pkg::*;
#(
    parameter logic [PROT_W-1:0] RESET_PROT = '1,
    parameter logic              RESET_LOCK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic [SR_W-1:0]   wr_data_i,
    input  logic              wp_n_i,
    input  logic              wel_set_i,
    input  logic              busy_i,
    output logic [SR_W-1:0]   status_o,
    output logic [PROT_W-1:0] prot_o,
    output logic              wr_ok_o,
    output logic              wr_rej_o
);
    sr_state_t st_d, st_q;
    logic      wel_q;
    logic      accept, refuse;

    sr_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set_i),
        .clr_i (wr_req_i),
        .q_o   (wel_q)
    );

    sr_wr_gate u_gate (
        .req_i    (wr_req_i),
        .wel_i    (wel_q),
        .lock_i   (st_q.lock),
        .wp_n_i   (wp_n_i),
        .accept_o (accept),
        .refuse_o (refuse)
    );

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy_i;
        st_d.ok   = accept;
        st_d.rej  = refuse;
        if (accept) begin
            st_d.lock = wr_data_i[LOCK_BIT];
            st_d.prot = wr_data_i[PROT_MSB:PROT_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= RESET_LOCK;
            st_q.prot <= RESET_PROT;
            st_q.busy <= 1'b0;
            st_q.ok   <= 1'b0;
            st_q.rej  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o                    = '0;
        status_o[LOCK_BIT]          = st_q.lock;
        status_o[PROT_MSB:PROT_LSB] = st_q.prot;
        status_o[WEL_BIT]           = wel_q;
        status_o[BUSY_BIT]          = st_q.busy;
    end

    assign prot_o   = st_q.prot;
    assign wr_ok_o  = st_q.ok;
    assign wr_rej_o = st_q.rej;

    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_i |=> (wr_ok_o ^ wr_rej_o));
    a_r9_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok_o || wr_rej_o) |-> $past(wr_req_i));
    a_r3_locked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !wp_n_i && status_o[LOCK_BIT]) |=>
            (wr_rej_o && $stable(status_o[SR_W-1:PROT_LSB])));
    a_r6_no_latch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !status_o[WEL_BIT]) |=>
            (wr_rej_o && $stable(status_o[SR_W-1:PROT_LSB])));
    a_r4_taken: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok_o |-> (prot_o == $past(wr_data_i[PROT_MSB:PROT_LSB])
                     && status_o[LOCK_BIT] == $past(wr_data_i[LOCK_BIT])));
    a_r5_pin_high_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wp_n_i && status_o[WEL_BIT]) |=> wr_ok_o);
    a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wr_data_i[SPARE_BIT]) |=> !status_o[SPARE_BIT]);
    a_r8_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wr_data_i[BUSY_BIT]) |=> status_o[BUSY_BIT] == $past(busy_i));
    a_r7_attempt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && wr_data_i[WEL_BIT]) |=> !status_o[WEL_BIT]);
    a_r2_prot_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        prot_o == status_o[PROT_MSB:PROT_LSB]);
endmodule

// File: tb/sim_sr_lockdown_status.sv
module sim_sr_lockdown_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wp_n = 1'b1;
    logic       wel_set = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] status;
    logic [3:0] prot;
    logic       wr_ok, wr_rej;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic       m_lock = 1'b0;
    logic [3:0] m_prot = 4'hF;
    logic       m_wel = 1'b0;
    logic       m_busy = 1'b0;
    logic       m_ok = 1'b0;
    logic       m_rej = 1'b0;

    always #2.5 clk = ~clk;

    sr_lockdown_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
        .wp_n_i(wp_n), .wel_set_i(wel_set), .busy_i(busy),
        .status_o(status), .prot_o(prot), .wr_ok_o(wr_ok), .wr_rej_o(wr_rej)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {m_lock, 1'b0, m_prot, m_wel, m_busy};
    endfunction

    // drive one cycle, update model, check at following negedge
    task automatic step(input logic req, input logic [7:0] d, input logic wp,
                        input logic set, input logic bz, input string tag);
        logic acc;
        wr_req = req; wr_data = d; wp_n = wp; wel_set = set; busy = bz;
        acc   = req && m_wel && (wp || !m_lock);
        m_ok  = acc;
        m_rej = req && !acc;
        if (acc) begin m_lock = d[7]; m_prot = d[5:2]; end
        if (req)      m_wel = 1'b0;
        else if (set) m_wel = 1'b1;
        m_busy = bz;
        @(negedge clk);
        check({tag, " status"}, status, m_status());
        check("R2 prot field", {4'h0, prot}, {4'h0, status[5:2]});
        check("R9 pulses", {6'h0, wr_ok, wr_rej}, {6'h0, m_ok, m_rej});
        check("R8 spare bit", {7'h0, status[6]}, 8'h00);
    endtask

    initial begin
        for (int c = 0; c < 4000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 8'h3C);
        check("R1 reset pulses", {6'h0, wr_ok, wr_rej}, 8'h00);

        for (int wp = 0; wp < 2; wp++)
            for (int bl = 0; bl < 2; bl++)
                for (int we = 0; we < 2; we++)
                    for (int p = 0; p < 4; p++) begin
                        string tg;
                        if (we == 0)      tg = "R6";
                        else if (wp == 1) tg = "R5";
                        else if (bl == 1) tg = "R3";
                        else              tg = "R4";
                        // prepare lock bit with the pin high
                        step(0, 8'h00, 1, 1, p[0], "R7 set");
                        step(1, {bl[0], 1'b1, 4'(p * 3 + 1), 2'b11}, 1, 0, p[1], "R5 prep");
                        step(0, 8'h00, 1, we[0], 1'b0, "R7 latch");
                        step(1, pats[p], wp[0], 0, p[0], tg);
                        check("R7 cleared", {7'h0, status[1]}, 8'h00);
                        step(0, 8'h00, wp[0], 0, 1'b1, "R9 idle");
                    end

        // collision: set strobe with attempt, latch clear then set
        step(1, 8'h00, 1, 0, 0, "R5 unlock");
        step(1, 8'h84, 1, 1, 0, "R7 collide clear");
        step(0, 8'h00, 1, 1, 0, "R7 set");
        step(1, 8'h84, 1, 1, 0, "R7 collide set");
        check("R7 collide value", status, 8'h84);
        step(0, 8'h00, 1, 0, 0, "R9 quiet");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule